// File: doc/BRIEF.md
# Flash Security Level Access Guard

This block sits on the in-system programming path in front of on-chip flash and decides, request by request, whether an operation may proceed. It stores a software security level that can only tighten over time. Each incoming operation is checked against that level, and the block either grants it or refuses it with an error code. Only a full chip erase can relax the level back to the open state.

The block also holds an 8-bit configuration byte. Its upper half acts as software-programmable fuse bits, writable only while the level is open. Its lower half is invisible to software writes and changes only through a parallel-programmer strobe. A programmed bit reads 0 and an erased bit reads 1. A synchronous reset loads the power-up contents: the level is open and the configuration byte takes a default with bits 6 and 2 programmed.

The block does not hold the flash itself, parse commands or run the serial transport. It only grants or refuses operations and updates its own level and configuration state.

Top module: `sec_guard`

## Requirements
- R1: While `rst` is high at a clock edge, the level becomes FFh, the configuration byte becomes BBh, and `grant` and `status` become 0.
- R2: A level write (op 2) whose `reqData` is stricter than the current level is granted with status 00 and stores `reqData` as the new level. Legal moves are FFh to FEh, FFh to FCh, and FEh to FCh.
- R3: A level write is refused with status 01 (write error) and the level is left unchanged in each of these cases: the code is not FEh or FCh, the code equals the current level, or the code is looser than the current level.
- R4: A full chip erase (op 3) is granted at every level and sets the level to FFh. No other operation lowers the level.
- R5: At level FEh, a flash write (op 1) is refused with status 01, and a flash read (op 0) is granted with status 00. At level FFh, both are granted.
- R6: At level FCh, a flash read (op 0) is refused with status 10 (vendor error), and a flash write (op 1) is refused with status 01.
- R7: A fuse write (op 5) at level FFh is granted and copies `reqData[7:4]` into configuration bits 7:4. At FEh or FCh it is refused with status 01 and the configuration byte is unchanged.
- R8: Blank check (op 4) and info read (op 6) are granted at every level. A block erase (op 7) is granted only at FFh and is otherwise refused with status 01.
- R9: Configuration bits 3:0 change only on a cycle with `progStrobe` high, where they take `progData`. This holds at any level, and a fuse write never alters them.
- R10: `grant` and `status` reflect a request in the cycle after the edge that samples `reqValid`. They are 0 in every cycle that follows an edge without a request, and `grant` is high only together with status 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | Operation request strobe |
| reqOp | input | 3 | Operation code (0 flash read, 1 flash write, 2 level write, 3 chip erase, 4 blank check, 5 fuse write, 6 info read, 7 block erase) |
| reqData | input | 8 | Target value: new level code or fuse data in bits 7:4 |
| progStrobe | input | 1 | Parallel-programmer write strobe for the hardware half |
| progData | input | 4 | Value for configuration bits 3:0 |
| grant | output | 1 | Previous-cycle request was granted |
| status | output | 2 | 00 ok, 01 write error, 10 vendor error |
| levelOut | output | 8 | Current security level |
| cfgOut | output | 8 | Current configuration byte |

## Verification
Every result is one register stage from its stimulus. The edge that samples a request also updates `grant`, `status`, the level and the configuration byte, so all four are due together in the cycle after that edge. The bench drives inputs on the falling edge and samples 1 ns after the next rising edge, where the result of the request must already be visible. It then drops the request and samples again one cycle later to confirm that `grant` and `status` have returned to zero. Strobe writes to the hardware half follow the same one-edge timing.

// File: rtl/sec_guard_pkg.sv
package sec_guard_pkg;

  typedef enum logic [2:0] {
    OP_FLASH_RD    = 3'd0,
    OP_FLASH_WR    = 3'd1,
    OP_LEVEL_WR    = 3'd2,
    OP_CHIP_ERASE  = 3'd3,
    OP_BLANK_CHK   = 3'd4,
    OP_FUSE_WR     = 3'd5,
    OP_INFO_RD     = 3'd6,
    OP_BLOCK_ERASE = 3'd7
  } opCode_e;

  typedef enum logic [1:0] {
    ST_OK         = 2'b00,
    ST_ERR_WRITE  = 2'b01,
    ST_ERR_VENDOR = 2'b10
  } status_e;

  localparam int          BYTE_W     = 8;
  localparam logic [7:0]  LVL_OPEN   = 8'hFF;
  localparam logic [7:0]  LVL_WPROT  = 8'hFE;
  localparam logic [7:0]  LVL_RWPROT = 8'hFC;

  typedef struct packed {
    logic              loadLevel;
    logic              clearLevel;
    logic              loadFuse;
    logic [BYTE_W-1:0] newLevel;
  } dpStrobe_t;

endpackage

// File: rtl/sec_guard_ctrl.sv
module sec_guard_ctrl
  import sec_guard_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  input  logic [2:0]        reqOp,
  input  logic [BYTE_W-1:0] reqData,
  input  logic [BYTE_W-1:0] levelQ,
  output dpStrobe_t         strobes,
  output logic              grant,
  output logic [1:0]        status
);

  opCode_e op;
  status_e errCode;
  logic    allow;
  logic    isOpen;
  logic    isLocked;
  logic    stricter;

  assign op       = opCode_e'(reqOp);
  assign isOpen   = (levelQ == LVL_OPEN);
  assign isLocked = (levelQ == LVL_RWPROT);
  // a new code is stricter when it is a legal code that clears a superset of bits
  assign stricter = ((reqData == LVL_WPROT) || (reqData == LVL_RWPROT)) &&
                    (reqData != levelQ) && ((reqData & levelQ) == reqData);

  always_comb begin
    allow   = 1'b1;
    errCode = ST_OK;
    unique case (op)
      OP_FLASH_RD: begin
        allow   = !isLocked;
        errCode = isLocked ? ST_ERR_VENDOR : ST_OK;
      end
      OP_FLASH_WR, OP_FUSE_WR, OP_BLOCK_ERASE: begin
        allow   = isOpen;
        errCode = isOpen ? ST_OK : ST_ERR_WRITE;
      end
      OP_LEVEL_WR: begin
        allow   = stricter;
        errCode = stricter ? ST_OK : ST_ERR_WRITE;
      end
      OP_CHIP_ERASE, OP_BLANK_CHK, OP_INFO_RD: begin
        allow   = 1'b1;
        errCode = ST_OK;
      end
    endcase
  end

  always_comb begin
    strobes          = '0;
    strobes.newLevel = reqData;
    if (reqValid && allow) begin
      strobes.loadLevel  = (op == OP_LEVEL_WR);
      strobes.clearLevel = (op == OP_CHIP_ERASE);
      strobes.loadFuse   = (op == OP_FUSE_WR);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      grant  <= 1'b0;
      status <= ST_OK;
    end else begin
      grant  <= reqValid && allow;
      status <= reqValid ? errCode : ST_OK;
    end
  end

  p_grant_clean_r10: assert property (@(posedge clk) disable iff (rst)
    grant |-> (status == 2'b00));

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    !reqValid |=> (!grant && status == 2'b00));

  p_locked_read_r6: assert property (@(posedge clk) disable iff (rst)
    (reqValid && reqOp == 3'd0 && levelQ == 8'hFC) |=> (status == 2'b10));

  p_same_level_r3: assert property (@(posedge clk) disable iff (rst)
    (reqValid && reqOp == 3'd2 && reqData == levelQ) |=> (status == 2'b01 && !grant));

endmodule

// File: rtl/sec_guard_dp.sv
module sec_guard_dp
  import sec_guard_pkg::*;
#(
  parameter logic [BYTE_W-1:0] CFG_RESET = 8'hBB,
  parameter int                HW_BITS   = 4
)(
  input  logic              clk,
  input  logic              rst,
  input  dpStrobe_t         strobes,
  input  logic [BYTE_W-1:0] fuseData,
  input  logic              progStrobe,
  input  logic [HW_BITS-1:0] progData,
  output logic [BYTE_W-1:0] levelQ,
  output logic [BYTE_W-1:0] cfgQ
);

  localparam int SW_LO = HW_BITS;

  always_ff @(posedge clk) begin
    if (rst) begin
      levelQ <= LVL_OPEN;
    end else if (strobes.clearLevel) begin
      levelQ <= LVL_OPEN;
    end else if (strobes.loadLevel) begin
      levelQ <= strobes.newLevel;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfgQ <= CFG_RESET;
    end else begin
      if (strobes.loadFuse)
        cfgQ[BYTE_W-1:SW_LO] <= fuseData[BYTE_W-1:SW_LO];
      if (progStrobe)
        cfgQ[HW_BITS-1:0] <= progData;
    end
  end

  p_level_legal_r2: assert property (@(posedge clk) disable iff (rst)
    (levelQ == 8'hFF) || (levelQ == 8'hFE) || (levelQ == 8'hFC));

  p_level_monotone_r4: assert property (@(posedge clk) disable iff (rst)
    !strobes.clearLevel |=> ((levelQ & $past(levelQ)) == levelQ));

  p_fuse_frozen_r7: assert property (@(posedge clk) disable iff (rst)
    (levelQ != 8'hFF) |=> $stable(cfgQ[BYTE_W-1:SW_LO]));

  p_hw_half_r9: assert property (@(posedge clk) disable iff (rst)
    !progStrobe |=> $stable(cfgQ[HW_BITS-1:0]));

endmodule

// File: rtl/sec_guard.sv
module sec_guard
  import sec_guard_pkg::*;
#(
  parameter logic [7:0] CFG_RESET = 8'hBB,
  parameter int         HW_BITS   = 4
)(
  input  logic               clk,
  input  logic               rst,
  input  logic               reqValid,
  input  logic [2:0]         reqOp,
  input  logic [7:0]         reqData,
  input  logic               progStrobe,
  input  logic [HW_BITS-1:0] progData,
  output logic               grant,
  output logic [1:0]         status,
  output logic [7:0]         levelOut,
  output logic [7:0]         cfgOut
);

  dpStrobe_t strobes;

  sec_guard_ctrl ctrl_i (
    .clk      (clk),
    .rst      (rst),
    .reqValid (reqValid),
    .reqOp    (reqOp),
    .reqData  (reqData),
    .levelQ   (levelOut),
    .strobes  (strobes),
    .grant    (grant),
    .status   (status)
  );

  sec_guard_dp #(
    .CFG_RESET (CFG_RESET),
    .HW_BITS   (HW_BITS)
  ) dp_i (
    .clk        (clk),
    .rst        (rst),
    .strobes    (strobes),
    .fuseData   (reqData),
    .progStrobe (progStrobe),
    .progData   (progData),
    .levelQ     (levelOut),
    .cfgQ       (cfgOut)
  );

endmodule

// File: tb/sec_guard_tb_top.sv
`timescale 1ns/1ps
module sec_guard_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reqValid = 1'b0;
  logic [2:0] reqOp = 3'd0;
  logic [7:0] reqData = 8'h00;
  logic       progStrobe = 1'b0;
  logic [3:0] progData = 4'h0;
  logic       grant;
  logic [1:0] status;
  logic [7:0] levelOut;
  logic [7:0] cfgOut;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  sec_guard dut_i (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqOp(reqOp), .reqData(reqData),
    .progStrobe(progStrobe), .progData(progData), .grant(grant), .status(status),
    .levelOut(levelOut), .cfgOut(cfgOut)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // issue one request, check response and state one edge later, then idle check
  task automatic req(input string tag, input logic [2:0] op, input logic [7:0] data,
                     input logic expGrant, input logic [1:0] expStatus,
                     input logic [7:0] expLevel, input logic [7:0] expCfg);
    @(negedge clk);
    reqValid = 1'b1; reqOp = op; reqData = data;
    @(posedge clk); #1;
    check({tag, " grant"},  {7'd0, grant}, {7'd0, expGrant});
    check({tag, " status"}, {6'd0, status}, {6'd0, expStatus});
    check({tag, " level"},  levelOut, expLevel);
    check({tag, " cfg"},    cfgOut, expCfg);
    @(negedge clk);
    reqValid = 1'b0;
    @(posedge clk); #1;
    check({tag, " R10 idle"}, {5'd0, grant, status}, 8'h00);
  endtask

  task automatic prog(input string tag, input logic [3:0] val, input logic [7:0] expCfg);
    @(negedge clk);
    progStrobe = 1'b1; progData = val;
    @(posedge clk); #1;
    check(tag, cfgOut, expCfg);
    @(negedge clk);
    progStrobe = 1'b0;
  endtask

  task automatic testReset();
    rst = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    check("R1 level", levelOut, 8'hFF);
    check("R1 cfg", cfgOut, 8'hBB);
    check("R1 resp", {5'd0, grant, status}, 8'h00);
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic testOpenLevel();
    req("R5 open read", 3'd0, 8'h00, 1, 2'b00, 8'hFF, 8'hBB);
    req("R5 open write", 3'd1, 8'h00, 1, 2'b00, 8'hFF, 8'hBB);
    req("R8 open block erase", 3'd7, 8'h00, 1, 2'b00, 8'hFF, 8'hBB);
    req("R7 fuse write", 3'd5, 8'hA5, 1, 2'b00, 8'hFF, 8'hAB);
    req("R3 bad code", 3'd2, 8'h55, 0, 2'b01, 8'hFF, 8'hAB);
    req("R3 same code", 3'd2, 8'hFF, 0, 2'b01, 8'hFF, 8'hAB);
  endtask

  task automatic testWriteProt();
    req("R2 to FE", 3'd2, 8'hFE, 1, 2'b00, 8'hFE, 8'hAB);
    req("R3 FE again", 3'd2, 8'hFE, 0, 2'b01, 8'hFE, 8'hAB);
    req("R3 looser", 3'd2, 8'hFF, 0, 2'b01, 8'hFE, 8'hAB);
    req("R5 prot read", 3'd0, 8'h00, 1, 2'b00, 8'hFE, 8'hAB);
    req("R5 prot write", 3'd1, 8'h00, 0, 2'b01, 8'hFE, 8'hAB);
    req("R7 fuse locked", 3'd5, 8'h00, 0, 2'b01, 8'hFE, 8'hAB);
    req("R8 block erase locked", 3'd7, 8'h00, 0, 2'b01, 8'hFE, 8'hAB);
    req("R8 blank FE", 3'd4, 8'h00, 1, 2'b00, 8'hFE, 8'hAB);
    req("R8 info FE", 3'd6, 8'h00, 1, 2'b00, 8'hFE, 8'hAB);
  endtask

  task automatic testRwProt();
    req("R2 FE to FC", 3'd2, 8'hFC, 1, 2'b00, 8'hFC, 8'hAB);
    req("R6 read", 3'd0, 8'h00, 0, 2'b10, 8'hFC, 8'hAB);
    req("R6 write", 3'd1, 8'h00, 0, 2'b01, 8'hFC, 8'hAB);
    req("R3 FC to FE", 3'd2, 8'hFE, 0, 2'b01, 8'hFC, 8'hAB);
    req("R7 fuse FC", 3'd5, 8'h0F, 0, 2'b01, 8'hFC, 8'hAB);
    req("R8 info FC", 3'd6, 8'h00, 1, 2'b00, 8'hFC, 8'hAB);
    req("R8 blank FC", 3'd4, 8'h00, 1, 2'b00, 8'hFC, 8'hAB);
    prog("R9 prog at FC", 4'h6, 8'hA6);
    req("R4 erase FC", 3'd3, 8'h00, 1, 2'b00, 8'hFF, 8'hA6);
  endtask

  task automatic testDirectAndHw();
    req("R2 FF to FC", 3'd2, 8'hFC, 1, 2'b00, 8'hFC, 8'hA6);
    req("R4 erase again", 3'd3, 8'h00, 1, 2'b00, 8'hFF, 8'hA6);
    req("R4 erase open", 3'd3, 8'h00, 1, 2'b00, 8'hFF, 8'hA6);
    req("R9 fuse keeps low", 3'd5, 8'h3C, 1, 2'b00, 8'hFF, 8'h36);
    prog("R9 prog open", 4'h9, 8'h39);
    @(posedge clk); #1;
    check("R9 hold", cfgOut, 8'h39);
  endtask

  initial begin
    testReset();
    testOpenLevel();
    testWriteProt();
    testRwProt();
    testDirectAndHw();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        nChecks++;
        nFails++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule